// File: doc/BRIEF.md
# I/Q Gain-Trim Calibration Controller

This block tunes the two 8-bit gain-trim codes that feed the fine current-adjust branches of a dual (in-phase and quadrature) DAC, so that the full-scale gains of the two channels move toward each other. Each code is sign-magnitude. The top bit selects whether current is added to or removed from the channel. The low seven bits set the size of the adjustment through weighted branches.

A run starts with a start pulse. Both codes are set to neutral and a baseline mismatch is requested from an external measuring path. That path answers with a valid strobe and an unsigned 16-bit mismatch number, where lower is better. The controller then runs a greedy search. It nudges one channel's code in that channel's preferred direction and requests a new measurement. A strictly better result keeps the nudge and tries the same channel again. Any other result restores the previous code and moves on to the other channel. When one failed trial on each channel follows the other without an improvement in between, the search has converged: the codes are held and `done` is raised. A programmable iteration limit ends a run that fails to converge in time and flags it as an error.

The weak-channel input fixes the preferred directions. The channel whose gain is below target is stepped additively, and the other channel is stepped subtractively.

Top module: `iq_trim_cal`

## Requirements
- R1: While reset is held and directly after it, both trim codes read 8'h80 and `busy`, `done`, `err` and `meas_req` are low.
- R2: Codes are sign-magnitude. Bit 7 = 1 means add current and bit 7 = 0 means subtract. Bits 6:0 carry the magnitude (0 to 127). A zero trim is always presented as 8'h80 and never as 8'h00.
- R3: A start pulse while idle raises `busy` and `meas_req` on the next cycle, with both codes at 8'h80, for the baseline measurement. A start pulse while busy has no effect on the run.
- R4: `meas_req` stays high, and both codes stay unchanged, until `meas_valid` is sampled high. A `meas_valid` pulse while no request is pending is ignored.
- R5: The first trial is on the I channel. With `i_is_low`=1 the I code is stepped additively and the Q code subtractively. With `i_is_low`=0 the directions are reversed.
- R6: Each trial moves one code by `step_size` LSBs (a value of 0 is taken as 1). The signed trim saturates at ±127. A trial that cannot move because of saturation counts as a failed trial and requests no measurement.
- R7: A trial whose measured value is strictly below the best so far is kept. That value becomes the new best, and the same channel is tried again.
- R8: A trial whose value is equal to or above the best has its channel code restored on the next cycle, and the other channel is tried next. Only one code changes in any cycle of a run.
- R9: Two consecutive failed trials end the run with `done`=1, `busy`=0 and `err`=0, and the codes are held until the next start.
- R10: Every measured trial counts as one iteration. When the count reaches `max_iter` without convergence, the run ends with `done`=1 and `err`=1. If convergence and the limit fall on the same evaluation, convergence wins and `err` stays 0.
- R11: A start pulse after a finished run clears `done` and `err` and begins a new run from neutral codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (acted on only when idle) |
| i_is_low | input | 1 | 1: I gain is below target; selects the step direction of each channel |
| step_size | input | 3 | Trial step in LSBs, 1 to 7 (0 acts as 1) |
| max_iter | input | 8 | Maximum number of measured trials per run |
| meas_req | output | 1 | Mismatch measurement requested |
| meas_valid | input | 1 | Measurement result strobe |
| meas_value | input | 16 | Unsigned mismatch result, lower is better |
| i_trim | output | 8 | I-channel sign-magnitude trim code |
| q_trim | output | 8 | Q-channel sign-magnitude trim code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; codes held |
| err | output | 1 | Run ended by the iteration limit |

## Verification
The completion of a search and the iteration limit can fall on the same measurement. This happens when the second consecutive rejected trial is also the `max_iter`-th evaluation. The bench provokes it by fixing a mismatch profile whose converging evaluation count is known (four trials) and running it with the limit set to that count and to one less. Convergence must win in the first case, with `err` low and the same held codes. The limit must win in the second, with `err` high and the rejected code already restored. A cycle model in the bench compares every output on every clock throughout.

// File: rtl/iq_trim_cal_pkg.sv
package iq_trim_cal_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,   // waiting for the baseline measurement
        ST_TRY  = 2'd2,   // forming the next trial
        ST_EVAL = 2'd3    // waiting for the trial measurement
    } cal_state_e;

endpackage

// File: rtl/iq_trim_stepper.sv
// Forms a trial trim value: current signed value moved by the step in the
// chosen direction, clamped to the symmetric magnitude limit.
module iq_trim_stepper #(
    parameter int TRIM_W = 8,
    parameter int STEP_W = 3
) (
    input  logic [TRIM_W-1:0] cur,
    input  logic              up,
    input  logic [STEP_W-1:0] step,
    output logic [TRIM_W-1:0] cand
);
    localparam int SUM_W = TRIM_W + STEP_W + 1;
    localparam int MAXM  = 2 ** (TRIM_W - 1) - 1;
    localparam logic [TRIM_W-1:0] POS_LIM = TRIM_W'(MAXM);
    localparam logic [TRIM_W-1:0] NEG_LIM = TRIM_W'(-MAXM);

    logic [STEP_W-1:0]        eff;
    logic signed [SUM_W-1:0]  cur_x;
    logic signed [SUM_W-1:0]  eff_x;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        eff   = (step == '0) ? STEP_W'(1) : step;
        cur_x = $signed({{(STEP_W+1){cur[TRIM_W-1]}}, cur});
        eff_x = $signed({{(TRIM_W+1){1'b0}}, eff});
        sum   = up ? (cur_x + eff_x) : (cur_x - eff_x);
        if (sum > MAXM)
            cand = POS_LIM;
        else if (sum < -MAXM)
            cand = NEG_LIM;
        else
            cand = sum[TRIM_W-1:0];
    end
endmodule

// File: rtl/iq_trim_pack.sv
// Signed trim value to sign-magnitude code (MSB 1 = add, zero shown as add).
module iq_trim_pack #(
    parameter int TRIM_W = 8
) (
    input  logic [TRIM_W-1:0] val,
    output logic [TRIM_W-1:0] code
);
    logic [TRIM_W-1:0] neg;

    always_comb begin
        neg = -val;
        if (val[TRIM_W-1])
            code = {1'b0, neg[TRIM_W-2:0]};
        else
            code = {1'b1, val[TRIM_W-2:0]};
    end
endmodule

// File: rtl/iq_trim_cal.sv
module iq_trim_cal
    import iq_trim_cal_pkg::*;
#(
    parameter int TRIM_W = 8,
    parameter int STEP_W = 3,
    parameter int ITER_W = 8,
    parameter int MEAS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              i_is_low,
    input  logic [STEP_W-1:0] step_size,
    input  logic [ITER_W-1:0] max_iter,
    output logic              meas_req,
    input  logic              meas_valid,
    input  logic [MEAS_W-1:0] meas_value,
    output logic [TRIM_W-1:0] i_trim,
    output logic [TRIM_W-1:0] q_trim,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int NCH = 2;   // index 0 = I, 1 = Q
    localparam logic [TRIM_W-1:0] ZERO_CODE = {1'b1, {(TRIM_W-1){1'b0}}};

    typedef struct packed {
        cal_state_e                   st;
        logic [NCH-1:0][TRIM_W-1:0]   val;
        logic [TRIM_W-1:0]            prev;
        logic                         ch;
        logic [1:0]                   fails;
        logic [ITER_W-1:0]            iter;
        logic [MEAS_W-1:0]            best;
        logic                         done;
        logic                         err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TRIM_W-1:0] cand [NCH];
    logic [TRIM_W-1:0] code [NCH];

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            iq_trim_stepper #(.TRIM_W(TRIM_W), .STEP_W(STEP_W)) u_step (
                .cur  (ctl_q.val[g]),
                .up   ((g == 0) ? i_is_low : ~i_is_low),
                .step (step_size),
                .cand (cand[g])
            );
            iq_trim_pack #(.TRIM_W(TRIM_W)) u_pack (
                .val  (ctl_q.val[g]),
                .code (code[g])
            );
        end
    endgenerate

    logic [ITER_W-1:0] iter_inc;
    logic [1:0]        fails_inc;
    logic [TRIM_W-1:0] cur_val;
    logic [TRIM_W-1:0] trial;
    logic              better;

    always_comb begin
        ctl_d     = ctl_q;
        iter_inc  = ctl_q.iter + 1'b1;
        fails_inc = ctl_q.fails + 2'd1;
        cur_val   = ctl_q.val[ctl_q.ch];
        trial     = cand[ctl_q.ch];
        better    = (meas_value < ctl_q.best);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st    = ST_BASE;
                    ctl_d.val   = '0;
                    ctl_d.ch    = 1'b0;
                    ctl_d.fails = '0;
                    ctl_d.iter  = '0;
                    ctl_d.done  = 1'b0;
                    ctl_d.err   = 1'b0;
                end
            end
            ST_BASE: begin
                if (meas_valid) begin
                    ctl_d.best = meas_value;
                    ctl_d.st   = ST_TRY;
                end
            end
            ST_TRY: begin
                if (trial == cur_val) begin
                    // saturated: failed trial without a measurement
                    ctl_d.fails = fails_inc;
                    if (fails_inc == 2'd2) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.ch = ~ctl_q.ch;
                    end
                end else begin
                    ctl_d.prev            = cur_val;
                    ctl_d.val[ctl_q.ch]   = trial;
                    ctl_d.st              = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (meas_valid) begin
                    ctl_d.iter = iter_inc;
                    if (better) begin
                        ctl_d.best  = meas_value;
                        ctl_d.fails = '0;
                    end else begin
                        ctl_d.val[ctl_q.ch] = ctl_q.prev;
                        ctl_d.fails         = fails_inc;
                        ctl_d.ch            = ~ctl_q.ch;
                    end
                    if (!better && fails_inc == 2'd2) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else if (iter_inc >= max_iter) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                    end else begin
                        ctl_d.st = ST_TRY;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign i_trim   = code[0];
    assign q_trim   = code[1];
    assign busy     = (ctl_q.st != ST_IDLE);
    assign meas_req = (ctl_q.st == ST_BASE) || (ctl_q.st == ST_EVAL);
    assign done     = ctl_q.done;
    assign err      = ctl_q.err;

    // ---------------- assertions ----------------
    function automatic logic signed [TRIM_W:0] unpack(input logic [TRIM_W-1:0] c);
        logic signed [TRIM_W:0] m;
        m = $signed({2'b00, c[TRIM_W-2:0]});
        return c[TRIM_W-1] ? m : -m;
    endfunction

    function automatic logic step_ok(input logic [TRIM_W-1:0] a,
                                     input logic [TRIM_W-1:0] b,
                                     input logic [STEP_W-1:0] s);
        logic signed [TRIM_W+1:0] diff;
        int lim;
        diff = unpack(a) - unpack(b);
        if (diff < 0) diff = -diff;
        lim = (s == '0) ? 1 : int'(s);
        return diff <= lim;
    endfunction

    assert_run_starts_neutral_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (i_trim == ZERO_CODE && q_trim == ZERO_CODE && meas_req));

    assert_no_negative_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (i_trim != '0) && (q_trim != '0));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && !meas_valid) |=> (meas_req && $stable(i_trim) && $stable(q_trim)));

    assert_one_code_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !((i_trim != $past(i_trim)) && (q_trim != $past(q_trim))));

    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (step_ok(i_trim, $past(i_trim), step_size)
                                   && step_ok(q_trim, $past(q_trim), step_size)));

    assert_err_only_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !busy));

    assert_done_is_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !meas_req));
endmodule

// File: tb/iq_trim_cal_test.sv
module iq_trim_cal_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        i_is_low = 1'b1;
    logic [2:0]  step_size = 3'd1;
    logic [7:0]  max_iter = 8'd50;
    logic        meas_req;
    logic        meas_valid = 1'b0;
    logic [15:0] meas_value = 16'd0;
    logic [7:0]  i_trim, q_trim;
    logic        busy, done, err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int off_v = 0;
    int lat = 0;
    bit spur = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    iq_trim_cal uut (
        .clk(clk), .rst_n(rst_n), .start(start), .i_is_low(i_is_low),
        .step_size(step_size), .max_iter(max_iter), .meas_req(meas_req),
        .meas_valid(meas_valid), .meas_value(meas_value),
        .i_trim(i_trim), .q_trim(q_trim), .busy(busy), .done(done), .err(err)
    );

    function automatic int enc(int v);
        return (v >= 0) ? (128 + v) : -v;
    endfunction

    function automatic int dec(logic [7:0] c);
        return c[7] ? int'(c[6:0]) : -int'(c[6:0]);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;          // 0 idle, 1 baseline, 2 trial, 3 evaluate
    int m_v[2] = '{0, 0};
    int m_prev = 0, m_ch = 0, m_fails = 0, m_iter = 0, m_best = 0;
    bit m_done = 0, m_err = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_v[0] = 0; m_v[1] = 0; m_prev = 0; m_ch = 0;
            m_fails = 0; m_iter = 0; m_best = 0; m_done = 0; m_err = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_v[0] = 0; m_v[1] = 0; m_ch = 0;
                    m_fails = 0; m_iter = 0; m_done = 0; m_err = 0;
                end
                1: if (meas_valid) begin
                    m_best = meas_value; m_st = 2;
                end
                2: begin
                    bit up;
                    int eff, c;
                    up  = (m_ch == 0) ? i_is_low : !i_is_low;
                    eff = (step_size == 0) ? 1 : int'(step_size);
                    c   = m_v[m_ch] + (up ? eff : -eff);
                    if (c > 127) c = 127;
                    if (c < -127) c = -127;
                    if (c == m_v[m_ch]) begin
                        m_fails++;
                        if (m_fails >= 2) begin m_st = 0; m_done = 1; end
                        else m_ch = 1 - m_ch;
                    end else begin
                        m_prev = m_v[m_ch]; m_v[m_ch] = c; m_st = 3;
                    end
                end
                3: if (meas_valid) begin
                    m_iter++;
                    if (int'(meas_value) < m_best) begin
                        m_best = meas_value; m_fails = 0;
                    end else begin
                        m_v[m_ch] = m_prev; m_fails++; m_ch = 1 - m_ch;
                    end
                    if (m_fails == 2) begin m_st = 0; m_done = 1; end
                    else if (m_iter >= int'(max_iter)) begin m_st = 0; m_done = 1; m_err = 1; end
                    else m_st = 2;
                end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison against the model (R7, R8 and all outputs)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ok;
            ok = (int'(i_trim) == enc(m_v[0])) && (int'(q_trim) == enc(m_v[1]))
                 && (busy == (m_st != 0)) && (done == m_done) && (err == m_err)
                 && (meas_req == (m_st == 1 || m_st == 3));
            chk(ok, "R7_R8 cycle model i_trim", int'(i_trim), enc(m_v[0]));
        end
    end

    // measurement responder: answers after a short latency with |off + I - Q|
    always @(negedge clk) begin
        if (spur) begin
            meas_valid = 1'b1;
            meas_value = 16'd0;
        end else if (meas_req && !meas_valid) begin
            if (lat == 0) begin
                int v;
                v = off_v + dec(i_trim) - dec(q_trim);
                if (v < 0) v = -v;
                if (v > 65535) v = 65535;
                meas_value = 16'(v);
                meas_valid = 1'b1;
                lat = 2;
            end else begin
                lat--;
            end
        end else begin
            meas_valid = 1'b0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic launch(int off, bit low, int step, int maxi);
        @(negedge clk);
        off_v = off; i_is_low = low; step_size = 3'(step); max_iter = 8'(maxi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!(done && !busy) && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(i_trim == 8'h80 && q_trim == 8'h80, "R1 codes in reset", int'(i_trim), 128);
        rst_n = 1'b1;
        @(negedge clk);
        chk(i_trim == 8'h80 && q_trim == 8'h80, "R1 codes after reset", int'(q_trim), 128);
        chk(!busy && !done && !err && !meas_req, "R1 flags after reset", int'(busy), 0);

        // stray strobe while idle
        spur = 1; @(negedge clk); spur = 0; @(negedge clk);
        chk(!busy && i_trim == 8'h80 && q_trim == 8'h80, "R4 stray valid ignored", int'(busy), 0);

        // start response
        launch(-20, 1'b1, 3, 50);
        chk(busy && meas_req && i_trim == 8'h80, "R3 start raises busy and request", int'(meas_req), 1);
        repeat (6) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;   // ignored, model keeps going
        wait_end();
        chk(i_trim == 8'h95, "R5 R7 I additive result", int'(i_trim), 'h95);
        chk(q_trim == 8'h80, "R8 Q restored to neutral", int'(q_trim), 'h80);
        chk(done && !err, "R9 converged without error", int'(err), 0);
        chk(!busy && !meas_req, "R3 start during run ignored, run ended once", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(i_trim == 8'h95 && done, "R9 codes held after done", int'(i_trim), 'h95);

        // restart and reversed direction
        launch(30, 1'b0, 4, 50);
        chk(!done && busy, "R11 restart clears done", int'(done), 0);
        wait_end();
        chk(i_trim == 8'h1C, "R5 R2 I subtractive code", int'(i_trim), 'h1C);
        chk(q_trim == 8'h80 && !err, "R8 Q trial undone", int'(q_trim), 'h80);

        // saturation at both ends
        launch(-400, 1'b1, 7, 100);
        wait_end();
        chk(i_trim == 8'hFF, "R6 I saturates at +127", int'(i_trim), 'hFF);
        chk(q_trim == 8'h7F, "R6 Q saturates at -127", int'(q_trim), 'h7F);
        chk(done && !err, "R6 R9 saturated trials end run", int'(err), 0);

        // step 0 acts as 1; converges on the 4th evaluation
        launch(-2, 1'b1, 0, 20);
        wait_end();
        chk(i_trim == 8'h82 && q_trim == 8'h80, "R6 zero step acts as one", int'(i_trim), 'h82);

        // convergence and limit on the same evaluation
        launch(-2, 1'b1, 0, 4);
        wait_end();
        chk(done && !err, "R10 convergence wins over limit", int'(err), 0);
        chk(i_trim == 8'h82, "R10 codes at coinciding limit", int'(i_trim), 'h82);

        // limit one short of convergence
        launch(-2, 1'b1, 0, 3);
        wait_end();
        chk(done && err, "R10 limit raises err", int'(err), 1);
        chk(i_trim == 8'h82 && q_trim == 8'h80, "R10 rejected code restored at limit", int'(i_trim), 'h82);

        // equal value is not an improvement
        launch(-1, 1'b1, 2, 20);
        wait_end();
        chk(i_trim == 8'h80 && q_trim == 8'h80, "R8 equal result rejected", int'(i_trim), 'h80);
        chk(done && !err, "R9 two rejections converge", int'(done), 1);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule